// File: doc/BRIEF.md
# PWM Fault Override and Polarity Output Stage

This block is the last stage between a PWM generator and the pins of four output pairs. Each pair has a high-side and a low-side pin. In normal running the stage takes the generator's logical levels, applies complementary pairing when that mode is on, maps active/inactive to electrical levels through one polarity bit for the high side and one for the low side, and registers the result. Each pin also has an output-enable bit. A pin whose enable is clear is released for general-purpose use.

There are two asynchronous fault inputs. Each one has a pair mask and a set of per-pin forced states. While a fault is asserted, every pair it covers is forced to its programmed active or inactive levels, measured against the polarity bits. If both faults cover the same pair, fault 0 wins. In complementary mode the high side has priority, so a pair never has both pins active. Each fault input sets a sticky interrupt flag on its rising edge, and a one-cycle clear strobe clears that flag. A reset configuration bit chooses whether the pins are tri-stated or driven inactive while reset is held.

Top module: `pwm_fault_stage`

## Requirements
- R1: While `rst_n` is low, `oe_h`/`oe_l` are all 0 if `rst_tristate` is 1. If `rst_tristate` is 0 they are all 1, and every pin drives its inactive level (`pin_h` = `pol_h`, `pin_l` = `pol_l`). `flt_irq` is 0.
- R2: With no fault forcing and `comp_mode` = 0, each pin reflects its generator bit one clock later as `pin = gen ^ pol`. A polarity bit of 1 means active-low.
- R3: With no fault forcing and `comp_mode` = 1, the low-side level of each pair is taken as the logical complement of that pair's high-side generator bit, and `gen_l` is ignored.
- R4: A fault input passes through two synchronizer flops and the output register. A level change sampled at one rising clock edge reaches the pins after the third rising edge. Pair p is forced when its mask bit `flt_mask[f*4+p]` is set. Its high-side state is bit `flt_state[f*8+2p]` and its low-side state is bit `flt_state[f*8+2p+1]`. A state bit of 1 means active and 0 means inactive.
- R5: Forced levels follow the polarity bits, so a forced-active pin drives `~pol` and a forced-inactive pin drives `pol`.
- R6: In complementary mode, a forced pair whose high and low states are both active drives the high side active and the low side inactive. With `comp_mode` = 0, both pins may be forced active.
- R7: A fault input whose mask bits are all zero leaves every pin unchanged, but it still sets its interrupt flag.
- R8: When both fault inputs are asserted and both cover a pair, that pair takes the states of fault 0.
- R9: Forcing follows the fault level. After the fault input deasserts, the pins return to normal operation with the same latency as in R4.
- R10: Out of reset, `oe_h[p]`/`oe_l[p]` equal `pin_en_h[p]`/`pin_en_l[p]` one clock later.
- R11: `flt_irq[f]` rises together with the first forced pin update after a rising edge of fault f, and then stays set. A one-cycle `flt_irq_clr[f]` clears it on the next edge. A new rising edge in the same cycle as a clear keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_tristate | input | 1 | Reset pin choice: 1 tri-state, 0 drive inactive |
| comp_mode | input | 1 | Complementary pairing enable |
| pol_h | input | 1 | High-side polarity, 1 = active-low |
| pol_l | input | 1 | Low-side polarity, 1 = active-low |
| pin_en_h | input | 4 | High-side pin enables |
| pin_en_l | input | 4 | Low-side pin enables |
| gen_h | input | 4 | Generator high-side logical levels |
| gen_l | input | 4 | Generator low-side logical levels |
| flt_in | input | 2 | Asynchronous fault inputs, active high |
| flt_mask | input | 8 | Pair masks, bit f*4+p |
| flt_state | input | 16 | Forced states, bit f*8+2p high, f*8+2p+1 low |
| flt_irq_clr | input | 2 | Write-one-to-clear strobes for the flags |
| pin_h | output | 4 | High-side pin levels |
| pin_l | output | 4 | Low-side pin levels |
| oe_h | output | 4 | High-side output enables |
| oe_l | output | 4 | Low-side output enables |
| flt_irq | output | 2 | Sticky fault interrupt flags |

## Verification
The bench builds the block with its defaults: four pairs, two fault inputs and a two-flop synchronizer. Two faults make it possible to test fault-0 precedence on a shared pair and to show that a fault with a zero mask still sets its flag. Four pairs let one fault cover some pairs and leave others alone, so forced and normal pins can be compared side by side. The two-flop depth fixes the three-edge latency that the bench samples around when checking both assertion and release.

// File: rtl/pwm_ovr_pkg.sv
package pwm_ovr_pkg;
    // logical (polarity-free) levels of one output pair
    typedef struct packed {
        logic hi;
        logic lo;
    } pair_act_t;
endpackage

// File: rtl/pwm_ovr_sync.sv
module pwm_ovr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_in;
        for (int k = 1; k < STAGES; k++) begin
            st_d.chain[k] = st_q.chain[k-1];
        end
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sync_out = st_q.chain[STAGES-1];
endmodule

// File: rtl/pwm_ovr_pair.sv
module pwm_ovr_pair
    import pwm_ovr_pkg::*;
#(
    parameter int NFLT = 2
) (
    input  logic            comp_mode,
    input  logic            gen_h,
    input  logic            gen_l,
    input  logic [NFLT-1:0] flt_hit,
    input  logic [NFLT-1:0] st_h,
    input  logic [NFLT-1:0] st_l,
    output pair_act_t       act
);
    logic forced;
    logic frc_h;
    logic frc_l;

    always_comb begin
        forced = 1'b0;
        frc_h  = 1'b0;
        frc_l  = 1'b0;
        // walk from the highest index down so fault 0 is applied last and wins
        for (int f = NFLT - 1; f >= 0; f--) begin
            if (flt_hit[f]) begin
                forced = 1'b1;
                frc_h  = st_h[f];
                frc_l  = st_l[f];
            end
        end
        if (forced) begin
            act.hi = frc_h;
            act.lo = frc_l & ~(comp_mode & frc_h);
        end else begin
            act.hi = gen_h;
            act.lo = comp_mode ? ~gen_h : gen_l;
        end
    end
endmodule

// File: rtl/pwm_fault_stage.sv
module pwm_fault_stage
    import pwm_ovr_pkg::*;
#(
    parameter int NPAIRS    = 4,
    parameter int NFLT      = 2,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rst_tristate,
    input  logic                       comp_mode,
    input  logic                       pol_h,
    input  logic                       pol_l,
    input  logic [NPAIRS-1:0]          pin_en_h,
    input  logic [NPAIRS-1:0]          pin_en_l,
    input  logic [NPAIRS-1:0]          gen_h,
    input  logic [NPAIRS-1:0]          gen_l,
    input  logic [NFLT-1:0]            flt_in,
    input  logic [NFLT*NPAIRS-1:0]     flt_mask,
    input  logic [NFLT*2*NPAIRS-1:0]   flt_state,
    input  logic [NFLT-1:0]            flt_irq_clr,
    output logic [NPAIRS-1:0]          pin_h,
    output logic [NPAIRS-1:0]          pin_l,
    output logic [NPAIRS-1:0]          oe_h,
    output logic [NPAIRS-1:0]          oe_l,
    output logic [NFLT-1:0]            flt_irq
);
    localparam int STATE_W = 2 * NPAIRS;

    typedef struct packed {
        logic [NPAIRS-1:0] lvl_h;
        logic [NPAIRS-1:0] lvl_l;
        logic [NPAIRS-1:0] en_h;
        logic [NPAIRS-1:0] en_l;
        logic [NFLT-1:0]   flag;
        logic [NFLT-1:0]   flt_prev;
    } out_state_t;

    out_state_t s_d, s_q;

    logic [NFLT-1:0]             flt_s;
    logic [NFLT-1:0][NPAIRS-1:0] hit_all;
    logic [NFLT-1:0][NPAIRS-1:0] st_h_all;
    logic [NFLT-1:0][NPAIRS-1:0] st_l_all;
    pair_act_t [NPAIRS-1:0]      act;

    pwm_ovr_sync #(
        .WIDTH  (NFLT),
        .STAGES (SYNC_DEPTH)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (flt_in),
        .sync_out (flt_s)
    );

    for (genvar f = 0; f < NFLT; f++) begin : g_flt
        for (genvar p = 0; p < NPAIRS; p++) begin : g_map
            assign hit_all[f][p]  = flt_s[f] & flt_mask[f*NPAIRS + p];
            assign st_h_all[f][p] = flt_state[f*STATE_W + 2*p];
            assign st_l_all[f][p] = flt_state[f*STATE_W + 2*p + 1];
        end
    end

    for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
        logic [NFLT-1:0] hit_p;
        logic [NFLT-1:0] sh_p;
        logic [NFLT-1:0] sl_p;
        for (genvar f = 0; f < NFLT; f++) begin : g_col
            assign hit_p[f] = hit_all[f][p];
            assign sh_p[f]  = st_h_all[f][p];
            assign sl_p[f]  = st_l_all[f][p];
        end
        pwm_ovr_pair #(
            .NFLT (NFLT)
        ) u_pair (
            .comp_mode (comp_mode),
            .gen_h     (gen_h[p]),
            .gen_l     (gen_l[p]),
            .flt_hit   (hit_p),
            .st_h      (sh_p),
            .st_l      (sl_p),
            .act       (act[p])
        );
    end

    always_comb begin
        s_d = s_q;
        for (int p = 0; p < NPAIRS; p++) begin
            s_d.lvl_h[p] = act[p].hi ^ pol_h;
            s_d.lvl_l[p] = act[p].lo ^ pol_l;
        end
        s_d.en_h     = pin_en_h;
        s_d.en_l     = pin_en_l;
        s_d.flt_prev = flt_s;
        // a new rising edge outranks a clear in the same cycle
        s_d.flag     = (s_q.flag & ~flt_irq_clr) | (flt_s & ~s_q.flt_prev);
        if (!rst_n) begin
            s_d.lvl_h    = {NPAIRS{pol_h}};
            s_d.lvl_l    = {NPAIRS{pol_l}};
            s_d.en_h     = {NPAIRS{~rst_tristate}};
            s_d.en_l     = {NPAIRS{~rst_tristate}};
            s_d.flag     = '0;
            s_d.flt_prev = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign pin_h   = s_q.lvl_h;
    assign pin_l   = s_q.lvl_l;
    assign oe_h    = s_q.en_h;
    assign oe_l    = s_q.en_l;
    assign flt_irq = s_q.flag;
endmodule

// File: rtl/pwm_ovr_chk.sv
module pwm_ovr_chk #(
    parameter int NPAIRS = 4,
    parameter int NFLT   = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rst_tristate,
    input logic                       comp_mode,
    input logic                       pol_h,
    input logic                       pol_l,
    input logic [NPAIRS-1:0]          pin_en_h,
    input logic [NPAIRS-1:0]          pin_en_l,
    input logic [NFLT-1:0]            flt_s,
    input logic [NFLT-1:0][NPAIRS-1:0] hit_all,
    input logic [NFLT-1:0][NPAIRS-1:0] st_h_all,
    input logic [NFLT-1:0]            flt_irq_clr,
    input logic [NPAIRS-1:0]          pin_h,
    input logic [NPAIRS-1:0]          pin_l,
    input logic [NPAIRS-1:0]          oe_h,
    input logic [NPAIRS-1:0]          oe_l,
    input logic [NFLT-1:0]            flt_irq
);
    a_r1_reset_enables: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (oe_h == {NPAIRS{~$past(rst_tristate)}}) &&
                         (oe_l == {NPAIRS{~$past(rst_tristate)}}));

    a_r10_oe_tracks_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (oe_h == $past(pin_en_h)) && (oe_l == $past(pin_en_l)));

    a_r6_pair_never_both_active: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(comp_mode) |->
            (((pin_h ^ {NPAIRS{$past(pol_h)}}) & (pin_l ^ {NPAIRS{$past(pol_l)}})) == '0));

    for (genvar p = 0; p < NPAIRS; p++) begin : g_p
        a_r4_fault0_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(hit_all[0][p]) |->
                pin_h[p] == ($past(st_h_all[0][p]) ^ $past(pol_h)));
    end

    for (genvar f = 0; f < NFLT; f++) begin : g_f
        a_r11_flag_needs_sync_fault: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flt_irq[f]) |-> $past(flt_s[f]));
        a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(flt_irq[f]) && !$past(flt_irq_clr[f]) |-> flt_irq[f]);
    end
endmodule

bind pwm_fault_stage pwm_ovr_chk #(
    .NPAIRS (NPAIRS),
    .NFLT   (NFLT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_tristate (rst_tristate),
    .comp_mode    (comp_mode),
    .pol_h        (pol_h),
    .pol_l        (pol_l),
    .pin_en_h     (pin_en_h),
    .pin_en_l     (pin_en_l),
    .flt_s        (flt_s),
    .hit_all      (hit_all),
    .st_h_all     (st_h_all),
    .flt_irq_clr  (flt_irq_clr),
    .pin_h        (pin_h),
    .pin_l        (pin_l),
    .oe_h         (oe_h),
    .oe_l         (oe_l),
    .flt_irq      (flt_irq)
);

// File: tb/test_pwm_fault_stage.sv
module test_pwm_fault_stage;
    localparam int N = 4;
    localparam int F = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         rst_tristate = 1'b1;
    logic         comp_mode = 1'b0;
    logic         pol_h = 1'b0;
    logic         pol_l = 1'b0;
    logic [N-1:0] pin_en_h = '1;
    logic [N-1:0] pin_en_l = '1;
    logic [N-1:0] gen_h = '0;
    logic [N-1:0] gen_l = '0;
    logic [F-1:0] flt_in = '0;
    logic [F*N-1:0]   flt_mask = '0;
    logic [F*2*N-1:0] flt_state = '0;
    logic [F-1:0] flt_irq_clr = '0;
    logic [N-1:0] pin_h, pin_l, oe_h, oe_l;
    logic [F-1:0] flt_irq;

    pwm_fault_stage i_pwm_fault_stage (
        .clk(clk), .rst_n(rst_n), .rst_tristate(rst_tristate),
        .comp_mode(comp_mode), .pol_h(pol_h), .pol_l(pol_l),
        .pin_en_h(pin_en_h), .pin_en_l(pin_en_l),
        .gen_h(gen_h), .gen_l(gen_l), .flt_in(flt_in),
        .flt_mask(flt_mask), .flt_state(flt_state), .flt_irq_clr(flt_irq_clr),
        .pin_h(pin_h), .pin_l(pin_l), .oe_h(oe_h), .oe_l(oe_l), .flt_irq(flt_irq)
    );

    typedef struct {
        logic [N-1:0] ph, pl, oh, ol;
        logic [F-1:0] fl;
        string        tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;
    logic [F-1:0] f_eff  = '0;
    logic [F-1:0] exp_fl = '0;

    // reference built from the requirement text
    function automatic exp_t model(string tag);
        exp_t e;
        for (int p = 0; p < N; p++) begin
            logic ah, al, sh, sl, frc;
            frc = 1'b0; sh = 1'b0; sl = 1'b0;
            for (int f = F - 1; f >= 0; f--) begin
                if (f_eff[f] && flt_mask[f*N+p]) begin
                    frc = 1'b1;
                    sh  = flt_state[f*2*N+2*p];
                    sl  = flt_state[f*2*N+2*p+1];
                end
            end
            if (frc) begin
                ah = sh;
                al = (comp_mode && sh) ? 1'b0 : sl;
            end else begin
                ah = gen_h[p];
                al = comp_mode ? ~gen_h[p] : gen_l[p];
            end
            e.ph[p] = ah ^ pol_h;
            e.pl[p] = al ^ pol_l;
        end
        e.oh = pin_en_h;
        e.ol = pin_en_l;
        e.fl = exp_fl;
        e.tag = tag;
        return e;
    endfunction

    task automatic push(exp_t e);
        sb_q.push_back(e);
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic drv_edge();
        @(negedge clk);
    endtask

    initial begin : monitor
        forever begin
            exp_t e;
            wait (sb_q.size() != 0);
            e = sb_q.pop_front();
            n_cmp++;
            if ({pin_h, pin_l, oe_h, oe_l, flt_irq} !== {e.ph, e.pl, e.oh, e.ol, e.fl}) begin
                n_bad++;
                $display("FAIL %s: actual ph=%b pl=%b oh=%b ol=%b irq=%b expected ph=%b pl=%b oh=%b ol=%b irq=%b",
                         e.tag, pin_h, pin_l, oe_h, oe_l, flt_irq, e.ph, e.pl, e.oh, e.ol, e.fl);
            end
        end
    end

    initial begin : watchdog
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        exp_t e;
        // R1: tri-state reset
        pol_h = 1'b1; pol_l = 1'b0;
        step(3);
        e = '{ph: 4'b1111, pl: 4'b0000, oh: 4'b0000, ol: 4'b0000, fl: 2'b00, tag: "R1 tristate"};
        push(e);
        drv_edge(); rst_tristate = 1'b0;
        step(1);
        e = '{ph: 4'b1111, pl: 4'b0000, oh: 4'b1111, ol: 4'b1111, fl: 2'b00, tag: "R1 driven inactive"};
        push(e);

        // R2: normal path, active-high then active-low
        drv_edge(); rst_n = 1'b1; pol_h = 1'b0; pol_l = 1'b0;
        gen_h = 4'b1010; gen_l = 4'b0110;
        step(1); push(model("R2 active-high"));
        drv_edge(); pol_h = 1'b1; pol_l = 1'b1; gen_h = 4'b0011; gen_l = 4'b0101;
        step(1); push(model("R2 active-low"));

        // R3: complementary, gen_l ignored
        drv_edge(); comp_mode = 1'b1; gen_h = 4'b1100; gen_l = 4'b1111;
        step(1); push(model("R3 complement"));

        // R10: per-pin enables
        drv_edge(); pin_en_h = 4'b0101; pin_en_l = 4'b1000;
        step(1); push(model("R10 enables"));
        drv_edge(); pin_en_h = '1; pin_en_l = '1; pol_h = 1'b0; pol_l = 1'b0;
        comp_mode = 1'b0; gen_h = 4'b1111; gen_l = 4'b1111;
        step(1); push(model("R2 restore"));

        // R4: fault 0 on pairs 0,1; pair0 H act L inact, pair1 H inact L act
        drv_edge();
        flt_mask[3:0] = 4'b0011;
        flt_state[7:0] = 8'b0000_1001;
        flt_in[0] = 1'b1;
        step(2); push(model("R4 not yet forced"));
        step(1); f_eff[0] = 1'b1; exp_fl[0] = 1'b1;
        push(model("R4 forced R11 flag set"));

        // R5: polarity-referenced forcing
        drv_edge(); pol_h = 1'b1; pol_l = 1'b1;
        step(1); push(model("R5 inverted polarity"));

        // R6: both active in complementary and non-complementary
        drv_edge(); pol_h = 1'b0; pol_l = 1'b0; comp_mode = 1'b1;
        flt_state[7:0] = 8'b0000_0011;
        step(1); push(model("R6 comp high wins"));
        drv_edge(); comp_mode = 1'b0;
        step(1); push(model("R6 non-comp both active"));

        // R9: release
        drv_edge(); flt_in[0] = 1'b0;
        step(2); push(model("R9 still forced"));
        step(1); f_eff[0] = 1'b0; push(model("R9 released"));

        // R11: clear, then set-wins-over-clear
        drv_edge(); flt_irq_clr[0] = 1'b1;
        step(1); exp_fl[0] = 1'b0; push(model("R11 cleared"));
        drv_edge(); flt_irq_clr[0] = 1'b0; flt_in[0] = 1'b1;
        step(2);
        flt_irq_clr[0] = 1'b1;
        step(1); f_eff[0] = 1'b1; exp_fl[0] = 1'b1;
        push(model("R11 set beats clear"));
        drv_edge(); flt_irq_clr[0] = 1'b0; flt_in[0] = 1'b0;
        step(3); f_eff[0] = 1'b0; push(model("R9 released again"));

        // R7: fault 1 with empty mask
        drv_edge(); flt_mask[7:4] = 4'b0000; flt_state[15:8] = 8'hFF; flt_in[1] = 1'b1;
        gen_h = 4'b0110; gen_l = 4'b1001;
        step(3); f_eff[1] = 1'b1; exp_fl[1] = 1'b1;
        push(model("R7 empty mask flag only"));

        // R8: overlap on pair 2, fault 1 alone on pair 1
        drv_edge();
        flt_mask[3:0]  = 4'b0100;
        flt_state[7:0] = 8'b0001_0000;
        flt_mask[7:4]  = 4'b0110;
        flt_state[15:8] = 8'b0010_1100;
        step(1); push(model("R8 fault1 alone"));
        drv_edge(); flt_in[0] = 1'b1;
        step(3); f_eff[0] = 1'b1; push(model("R8 fault0 precedence"));
        drv_edge(); flt_in[0] = 1'b0;
        step(3); f_eff[0] = 1'b0; push(model("R8 fault1 takes pair2"));

        #3;
        wait (sb_q.size() == 0);
        #1;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule